// File: doc/BRIEF.md
# Serial Flash Power-Mode Controller

This block is the device-side command front end of a serial memory that decides between normal standby and the deep power-down state. It watches the chip-select, serial clock and serial data pins in SPI mode 0 and takes the data pin in on each rising serial clock edge while chip select is low. It builds the first byte of each frame, most significant bit first, as the opcode. When chip select rises, it checks whether the frame ended on a whole number of bytes. It then either hands the command to the rest of the device or discards it.

A frame carrying the power-down opcode makes the device pass through a timed entry phase into deep power-down. This happens only if the frame is byte-aligned and no internal program or erase operation is running. In deep power-down the device discards every frame except the resume opcode, so status reads and program or erase requests cannot reach the rest of the device. A byte-aligned resume frame starts a timed recovery phase that ends in standby. The pins are sampled by a system clock after a parameterised synchroniser. The entry and recovery times are parameters counted in system clocks.

Top module: `pm_power_ctrl`

## Requirements
- R1: After power-on reset the power state is standby (`pwrState` = 2'b00), `cmdValid` is low and `soOe` is low.
- R2: In standby, a frame whose chip select rises after 8·k serial clock edges (k ≥ 1) commits. `cmdValid` pulses for exactly one clock, and `cmdCode` holds the first byte of the frame, taken MSB first.
- R3: A frame with fewer than 8 bits, or a bit count that is not a multiple of 8, produces no `cmdValid` pulse and leaves `pwrState` unchanged. This includes a misaligned power-down frame (opcode 0xB9).
- R4: In standby with busy low, a byte-aligned frame with opcode 0xB9 commits. This holds even when more bytes follow the opcode. The strobe fires and `pwrState` reads entering (2'b01) for exactly ENTRY_CYC clocks, starting in the strobe cycle, then deep power-down (2'b10).
- R5: A 0xB9 frame that ends while busy is high produces no strobe and keeps standby. Standby is still held after busy falls; the request is not deferred.
- R6: In deep power-down, a frame with any opcode other than 0xAB gives no strobe, keeps `pwrState` at 2'b10 and never raises `soOe`. This covers status read 0x05, program 0x02 and 0xB9.
- R7: In deep power-down, a byte-aligned 0xAB frame commits. `pwrState` reads waking (2'b11) for exactly WAKE_CYC clocks, starting in the strobe cycle, then standby. A misaligned 0xAB frame leaves the device in deep power-down.
- R8: `soOe` rises in standby only during a status-read frame (opcode 0x05), once its first 8 bits are in, and falls after chip select rises. It stays low for every other opcode, including the whole 0xB9 frame.
- R9: Each chip-select-low frame counts from bit 0, so an aborted misaligned frame does not disturb the alignment or opcode of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, SPI mode 0 |
| si | input | 1 | Serial data in, MSB first |
| busy | input | 1 | High while an internal program or erase operation runs |
| pwrState | output | 2 | 00 standby, 01 entering, 10 deep power-down, 11 waking |
| cmdValid | output | 1 | One-clock strobe for a committed command |
| cmdCode | output | 8 | Opcode of the last committed command |
| soOe | output | 1 | Output enable for the serial data out driver |

## Verification
The bench builds the block with ENTRY_CYC = 3 and WAKE_CYC = 4 and keeps the default two-stage synchroniser. With such short windows, the number of cycles spent entering and waking can be counted exactly, edge to edge, after each strobe. The defaults are far longer and would only stretch the run. The directed frames cover short, misaligned, multi-byte and busy-gated cases in both standby and deep power-down, so the blocking of status, program and repeated power-down requests is observed at the strobe and output-enable pins.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int OP_W = 8;

  typedef enum logic [1:0] {
    PS_STANDBY  = 2'b00,
    PS_ENTERING = 2'b01,
    PS_DEEP     = 2'b10,
    PS_WAKING   = 2'b11
  } pwr_state_e;

  localparam logic [OP_W-1:0] OP_DPD    = 8'hB9;
  localparam logic [OP_W-1:0] OP_RESUME = 8'hAB;
  localparam logic [OP_W-1:0] OP_STATUS = 8'h05;

  // datapath -> control: what the frame looked like when chip select rose
  typedef struct packed {
    logic            frameEnd;
    logic            aligned;
    logic [OP_W-1:0] opcode;
  } frame_info_t;

  // control -> datapath strobes
  typedef struct packed {
    logic soAllow;
  } dp_ctl_t;
endpackage

// File: rtl/pm_delay.sv
module pm_delay #(
  parameter int CYC = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic expired
);
  localparam int W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [W-1:0] LOAD = W'(CYC - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (start)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pm_frame_dp.sv
module pm_frame_dp
  import pm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sck,
  input  logic        si,
  input  dp_ctl_t     ctl,
  output frame_info_t info,
  output logic        soOe
);
  localparam int IDX_W = $clog2(OP_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OP_W - 1);

  // bit 2: chip select, bit 1: serial clock, bit 0: data
  logic [2:0] rawIn;
  logic [2:0] syncOut;
  assign rawIn = {csN, sck, si};

  logic [SYNC_STAGES-1:0][2:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 3'b100;
        else       syncQ <= rawIn;
      end
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= {SYNC_STAGES{3'b100}};
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  logic csS, sckS, siS;
  assign csS  = syncOut[2];
  assign sckS = syncOut[1];
  assign siS  = syncOut[0];

  logic csPrev, sckPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  logic csRise, sckRise;
  assign csRise  = csS & ~csPrev;
  assign sckRise = sckS & ~sckPrev & ~csS;

  logic [OP_W-1:0]  shiftReg;
  logic [OP_W-1:0]  opcodeReg;
  logic [IDX_W-1:0] bitIdx;
  logic             opcodeSeen;
  logic [OP_W-1:0]  shiftNext;

  assign shiftNext = {shiftReg[OP_W-2:0], siS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      opcodeReg  <= '0;
      bitIdx     <= '0;
      opcodeSeen <= 1'b0;
    end else if (csS) begin
      // frame idle or just ended: next frame starts at bit 0
      shiftReg   <= '0;
      opcodeReg  <= '0;
      bitIdx     <= '0;
      opcodeSeen <= 1'b0;
    end else if (sckRise) begin
      shiftReg <= shiftNext;
      bitIdx   <= bitIdx + 1'b1;
      if (!opcodeSeen && bitIdx == LAST_IDX) begin
        opcodeReg  <= shiftNext;
        opcodeSeen <= 1'b1;
      end
    end
  end

  assign info.frameEnd = csRise;
  assign info.aligned  = opcodeSeen & (bitIdx == '0);
  assign info.opcode   = opcodeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) soOe <= 1'b0;
    else       soOe <= ctl.soAllow & ~csS & opcodeSeen & (opcodeReg == OP_STATUS);
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  frame_info_t     info,
  input  logic            busy,
  input  logic            entryDone,
  input  logic            wakeDone,
  output logic            startEntry,
  output logic            startWake,
  output dp_ctl_t         ctl,
  output pwr_state_e      state,
  output logic            cmdValid,
  output logic [OP_W-1:0] cmdCode
);
  pwr_state_e stateNext;
  logic       frameOk;
  logic       commit;

  assign frameOk = info.frameEnd & info.aligned;

  always_comb begin
    stateNext  = state;
    commit     = 1'b0;
    startEntry = 1'b0;
    startWake  = 1'b0;
    case (state)
      PS_STANDBY: begin
        if (frameOk) begin
          if (info.opcode == OP_DPD) begin
            if (!busy) begin
              commit     = 1'b1;
              startEntry = 1'b1;
              stateNext  = PS_ENTERING;
            end
          end else begin
            commit = 1'b1;
          end
        end
      end
      PS_ENTERING: begin
        if (entryDone) stateNext = PS_DEEP;
      end
      PS_DEEP: begin
        if (frameOk && info.opcode == OP_RESUME) begin
          commit    = 1'b1;
          startWake = 1'b1;
          stateNext = PS_WAKING;
        end
      end
      PS_WAKING: begin
        if (wakeDone) stateNext = PS_STANDBY;
      end
      default: stateNext = PS_STANDBY;
    endcase
  end

  assign ctl.soAllow = (state == PS_STANDBY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PS_STANDBY;
      cmdValid <= 1'b0;
      cmdCode  <= '0;
    end else begin
      state    <= stateNext;
      cmdValid <= commit;
      if (commit) cmdCode <= info.opcode;
    end
  end
endmodule

// File: rtl/pm_power_ctrl.sv
module pm_power_ctrl
  import pm_pkg::*;
#(
  parameter int ENTRY_CYC   = 300,
  parameter int WAKE_CYC    = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       busy,
  output logic [1:0] pwrState,
  output logic       cmdValid,
  output logic [7:0] cmdCode,
  output logic       soOe
);
  frame_info_t info;
  dp_ctl_t     ctl;
  pwr_state_e  state;
  logic        startEntry, startWake, entryDone, wakeDone;

  pm_frame_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .ctl(ctl), .info(info), .soOe(soOe)
  );

  pm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .info(info), .busy(busy),
    .entryDone(entryDone), .wakeDone(wakeDone),
    .startEntry(startEntry), .startWake(startWake),
    .ctl(ctl), .state(state), .cmdValid(cmdValid), .cmdCode(cmdCode)
  );

  pm_delay #(.CYC(ENTRY_CYC)) u_entryDly (
    .clk(clk), .rstN(rstN), .start(startEntry), .expired(entryDone)
  );

  pm_delay #(.CYC(WAKE_CYC)) u_wakeDly (
    .clk(clk), .rstN(rstN), .start(startWake), .expired(wakeDone)
  );

  assign pwrState = state;
endmodule

// File: rtl/pm_power_ctrl_chk.sv
module pm_power_ctrl_chk
  import pm_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwrState,
  input logic       cmdValid,
  input logic [7:0] cmdCode,
  input logic       soOe
);
  // R6: only resume leaves a strobe when the previous state was deep power-down
  a_r6_deep_blocks_cmds: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(pwrState) == PS_STANDBY) ||
                 ($past(pwrState) == PS_DEEP && cmdCode == OP_RESUME));

  // R8: data-out driver enabled only in standby
  a_r8_so_only_standby: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> $past(pwrState) == PS_STANDBY);

  // R4: entering phase leads only to deep power-down
  a_r4_entry_path: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == PS_ENTERING |=> pwrState == PS_ENTERING || pwrState == PS_DEEP);

  // R4: entering phase begins together with a power-down strobe
  a_r4_entry_from_dpd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrState == PS_ENTERING) |-> cmdValid && cmdCode == OP_DPD);

  // R5: a committed power-down always starts entry (busy frames never strobe)
  a_r5_dpd_strobe_enters: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == OP_DPD |-> pwrState == PS_ENTERING);

  // R7: deep power-down is left only through the waking phase
  a_r7_deep_exit: assert property (@(posedge clk) disable iff (!rstN)
    pwrState == PS_DEEP |=> pwrState == PS_DEEP || pwrState == PS_WAKING);

  // R2: strobe lasts one clock
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
endmodule

bind pm_power_ctrl pm_power_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrState(pwrState), .cmdValid(cmdValid),
  .cmdCode(cmdCode), .soOe(soOe)
);

// File: tb/sim_pm_power_ctrl.sv
`timescale 1ns/1ps
module sim_pm_power_ctrl;
  localparam int ENTRY_CYC = 3;
  localparam int WAKE_CYC  = 4;
  localparam int HALF      = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
  logic [1:0] pwrState;
  logic       cmdValid, soOe;
  logic [7:0] cmdCode;

  always #2 clk = ~clk;

  pm_power_ctrl #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .busy(busy),
    .pwrState(pwrState), .cmdValid(cmdValid), .cmdCode(cmdCode), .soOe(soOe)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // observation, sampled at negedge
  int strobeCnt, enterCnt, wakeCnt;
  logic [7:0] lastCode;
  logic [1:0] stateAtStrobe;
  bit soSeen;

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid) begin
        strobeCnt++;
        lastCode = cmdCode;
        stateAtStrobe = pwrState;
      end
      if (pwrState == 2'b01) enterCnt++;
      if (pwrState == 2'b11) wakeCnt++;
      if (soOe) soSeen = 1;
    end
  end

  task automatic clearObs();
    strobeCnt = 0; enterCnt = 0; wakeCnt = 0; soSeen = 0;
    lastCode = 8'h00; stateAtStrobe = 2'b00;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // send nbits taken MSB first from the left of pat
  task automatic frame(input logic [31:0] pat, input int nbits);
    clearObs();
    cyc(1);
    csN = 1'b0;
    cyc(HALF);
    for (int i = 0; i < nbits; i++) begin
      si = pat[31-i];
      cyc(HALF);
      sck = 1'b1;
      cyc(HALF);
      sck = 1'b0;
    end
    cyc(HALF);
    csN = 1'b1;
    cyc(20);
  endtask

  task automatic t_reset();
    chk(pwrState == 2'b00, "R1", "state", pwrState, 0);
    chk(cmdValid == 1'b0, "R1", "strobe", cmdValid, 0);
    chk(soOe == 1'b0, "R1", "soOe", soOe, 0);
  endtask

  task automatic t_plain();
    frame(32'h0600_0000, 8);
    chk(strobeCnt == 1, "R2", "strobe count 8b", strobeCnt, 1);
    chk(lastCode == 8'h06, "R2", "code 8b", lastCode, 8'h06);
    frame(32'h0212_3456, 32);
    chk(strobeCnt == 1, "R2", "strobe count 32b", strobeCnt, 1);
    chk(lastCode == 8'h02, "R2", "code 32b", lastCode, 8'h02);
    chk(pwrState == 2'b00, "R2", "state", pwrState, 0);
  endtask

  task automatic t_misaligned();
    frame(32'h0600_0000, 12);
    chk(strobeCnt == 0, "R3", "12-bit frame strobes", strobeCnt, 0);
    frame(32'hB800_0000, 5);
    chk(strobeCnt == 0, "R3", "5-bit frame strobes", strobeCnt, 0);
    frame(32'hB900_0000, 12);
    chk(strobeCnt == 0, "R3", "misaligned B9 strobes", strobeCnt, 0);
    chk(pwrState == 2'b00, "R3", "state after misaligned B9", pwrState, 0);
  endtask

  task automatic t_restart();
    frame(32'hFF00_0000, 3);
    chk(strobeCnt == 0, "R9", "3-bit frame strobes", strobeCnt, 0);
    frame(32'h2000_0000, 8);
    chk(strobeCnt == 1, "R9", "next frame strobes", strobeCnt, 1);
    chk(lastCode == 8'h20, "R9", "next frame code", lastCode, 8'h20);
  endtask

  task automatic t_status();
    frame(32'h0500_0000, 16);
    chk(soSeen == 1, "R8", "soOe during status", soSeen, 1);
    chk(soOe == 1'b0, "R8", "soOe after frame", soOe, 0);
    chk(lastCode == 8'h05, "R8", "status code", lastCode, 8'h05);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    frame(32'hB900_0000, 8);
    chk(strobeCnt == 0, "R5", "busy B9 strobes", strobeCnt, 0);
    chk(pwrState == 2'b00, "R5", "busy B9 state", pwrState, 0);
    busy = 1'b0;
    cyc(30);
    chk(pwrState == 2'b00, "R5", "state after busy drops", pwrState, 0);
  endtask

  task automatic t_enter();
    frame(32'hB9C3_0000, 16);
    chk(strobeCnt == 1, "R4", "B9 strobes", strobeCnt, 1);
    chk(lastCode == 8'hB9, "R4", "B9 code", lastCode, 8'hB9);
    chk(stateAtStrobe == 2'b01, "R4", "state at strobe", stateAtStrobe, 1);
    chk(enterCnt == ENTRY_CYC, "R4", "entering cycles", enterCnt, ENTRY_CYC);
    chk(pwrState == 2'b10, "R4", "deep state", pwrState, 2);
    chk(soSeen == 0, "R8", "soOe during B9 frame", soSeen, 0);
  endtask

  task automatic t_deep_block();
    frame(32'h0500_0000, 16);
    chk(strobeCnt == 0, "R6", "status in deep strobes", strobeCnt, 0);
    chk(soSeen == 0, "R6", "soOe in deep", soSeen, 0);
    frame(32'h0200_1122, 32);
    chk(strobeCnt == 0, "R6", "program in deep strobes", strobeCnt, 0);
    frame(32'hB900_0000, 8);
    chk(strobeCnt == 0, "R6", "B9 in deep strobes", strobeCnt, 0);
    chk(pwrState == 2'b10, "R6", "still deep", pwrState, 2);
    frame(32'hAB00_0000, 10);
    chk(strobeCnt == 0, "R7", "misaligned AB strobes", strobeCnt, 0);
    chk(pwrState == 2'b10, "R7", "deep after misaligned AB", pwrState, 2);
  endtask

  task automatic t_resume();
    frame(32'hAB00_0000, 8);
    chk(strobeCnt == 1, "R7", "AB strobes", strobeCnt, 1);
    chk(lastCode == 8'hAB, "R7", "AB code", lastCode, 8'hAB);
    chk(stateAtStrobe == 2'b11, "R7", "state at strobe", stateAtStrobe, 3);
    chk(wakeCnt == WAKE_CYC, "R7", "waking cycles", wakeCnt, WAKE_CYC);
    chk(pwrState == 2'b00, "R7", "standby after wake", pwrState, 0);
  endtask

  initial begin
    clearObs();
    cyc(5);
    t_reset();
    rstN = 1'b1;
    cyc(5);
    t_reset();
    t_plain();
    t_misaligned();
    t_restart();
    t_status();
    t_busy();
    t_enter();
    t_deep_block();
    t_resume();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule